// File: doc/BRIEF.md
# Chip Memory Region Address Decoder

This block decides whether a CPU bus cycle falls into memory that sits on the chip-RAM bus. It takes only the seven upper bits of a 24-bit byte address (bit 17 up to bit 23), so each input value stands for a 128 KB block. When the address strobe is active it raises a RAM enable for the low chip window, 0x000000 up to but not including 0x200000. An active-low strap adds a second window, 0xC00000 up to but not including 0xD80000. The strap is a plain level input. It may be tied to ground for good, or driven from an expansion connector.

The RAM enable is combinational. It follows the strobe in the same cycle, in both directions. A 2-bit region code is registered on each clock edge, so it reports the window that was decoded one clock earlier. DRAM timing, bus arbitration and other chip selects are handled outside this block.

Top module: `chipdec_top`

## Requirements
- R1: While `as_n` is 0 and `cpu_addr_hi` is below 16 (byte address below 0x200000), `ram_en` is 1 in the same cycle.
- R2: While `as_n` is 0, `ext_ram_n` is 0 and `cpu_addr_hi` is from 96 to 107 inclusive (0xC00000 to 0xD7FFFF), `ram_en` is 1 in the same cycle.
- R3: While `ext_ram_n` is 1, addresses with `cpu_addr_hi` from 96 to 107 give `ram_en` = 0.
- R4: Addresses with `cpu_addr_hi` from 16 to 95, or from 108 to 127, give `ram_en` = 0 whatever the strap level.
- R5: `ram_en` is 0 in every cycle in which `as_n` is 1, including the cycle in which the strobe is released.
- R6: On each rising clock edge, `region` takes the code of the window decoded at that edge: 2'b01 for the low window and 2'b10 for the enabled upper window. It takes 2'b00 for an unmapped address, for the upper window with the strap inactive, or when `as_n` is 1.
- R7: While `rst_n` is 0, `region` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr_hi | input | 7 | CPU byte address bits 23..17 |
| as_n | input | 1 | Address strobe, active low |
| ext_ram_n | input | 1 | Upper-window strap, active low |
| ram_en | output | 1 | Chip-RAM enable, combinational |
| region | output | 2 | Registered region code (00 none, 01 low, 10 upper) |

## Verification
The assertions take for granted that the address bits and the strap are stable around each rising edge, because they check the registered region code against values sampled at that edge. The stimulus changes all inputs only on falling edges. It sweeps all 128 address blocks under each strap level, once with the strobe active and once with it inactive. This covers the window edges at 15/16, 95/96 and 107/108.

// File: rtl/chipdec_pkg.sv
package chipdec_pkg;

  typedef enum logic [1:0] {
    REG_NONE  = 2'b00,
    REG_LOW   = 2'b01,
    REG_UPPER = 2'b10
  } region_e;

  // Pick the region code from the two qualified window hits.
  function automatic region_e pick_region(input logic strobe, input logic low_hit,
                                          input logic upper_hit);
    if (!strobe)        return REG_NONE;
    else if (low_hit)   return REG_LOW;
    else if (upper_hit) return REG_UPPER;
    else                return REG_NONE;
  endfunction

endpackage

// File: rtl/chipdec_window.sv
module chipdec_window #(
  parameter int HI_W  = 7,
  parameter int START = 0,
  parameter int STOP  = 16
) (
  input  logic [HI_W-1:0] hi,
  output logic            hit
);
  localparam logic [HI_W:0] STOP_V  = STOP[HI_W:0];
  localparam logic [HI_W:0] START_V = START[HI_W:0];

  logic [HI_W:0] hi_ext;
  assign hi_ext = {1'b0, hi};

  generate
    if (START == 0) begin : g_from_zero
      assign hit = hi_ext < STOP_V;
    end else begin : g_span
      assign hit = (hi_ext >= START_V) && (hi_ext < STOP_V);
    end
  endgenerate
endmodule

// File: rtl/chipdec_region_reg.sv
module chipdec_region_reg
  import chipdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       low_hit,
  input  logic       upper_hit,
  output logic [1:0] region
);
  region_e nxt;
  assign nxt = pick_region(strobe, low_hit, upper_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) region <= REG_NONE;
    else        region <= nxt;
  end

  // R6: region code is never both windows at once
  a_r6_onehot_region: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region));
  // R6: strobe idle at an edge leaves no region afterwards
  a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> region == 2'b00);
  // R6: a low hit under strobe is reported next cycle
  a_r6_low_reported: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && low_hit |=> region == 2'b01);
  // R6: an enabled upper hit under strobe is reported next cycle
  a_r6_upper_reported: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && upper_hit && !low_hit |=> region == 2'b10);
endmodule

// File: rtl/chipdec_top.sv
module chipdec_top #(
  parameter int HI_W     = 7,
  parameter int ADDR_LSB = 17,
  parameter int LOW_BASE = 24'h000000,
  parameter int LOW_LIM  = 24'h200000,
  parameter int UP_BASE  = 24'hC00000,
  parameter int UP_LIM   = 24'hD80000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] cpu_addr_hi,
  input  logic            as_n,
  input  logic            ext_ram_n,
  output logic            ram_en,
  output logic [1:0]      region
);
  localparam int LOW_START = LOW_BASE >> ADDR_LSB;
  localparam int LOW_STOP  = LOW_LIM  >> ADDR_LSB;
  localparam int UP_START  = UP_BASE  >> ADDR_LSB;
  localparam int UP_STOP   = UP_LIM   >> ADDR_LSB;

  logic strobe;
  logic low_hit;
  logic up_raw;
  logic up_hit;

  assign strobe = !as_n;

  chipdec_window #(.HI_W(HI_W), .START(LOW_START), .STOP(LOW_STOP)) u_low (
    .hi (cpu_addr_hi),
    .hit(low_hit)
  );

  chipdec_window #(.HI_W(HI_W), .START(UP_START), .STOP(UP_STOP)) u_up (
    .hi (cpu_addr_hi),
    .hit(up_raw)
  );

  assign up_hit = up_raw && !ext_ram_n;
  assign ram_en = strobe && (low_hit || up_hit);

  chipdec_region_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .low_hit  (low_hit),
    .upper_hit(up_hit),
    .region   (region)
  );

  // R1: low window under strobe enables RAM
  a_r1_low_enables: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && low_hit |-> ram_en);
  // R3: strap inactive keeps the upper window dark
  a_r3_strap_off: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ram_n && up_raw |-> !ram_en);
  // R4: outside both windows nothing is enabled
  a_r4_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    !low_hit && !up_raw |-> !ram_en);
  // R5: enable never outlives the strobe
  a_r5_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> !ram_en);
endmodule

// File: tb/chipdec_top_test.sv
module chipdec_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cpu_addr_hi = '0;
  logic       as_n = 1'b1;
  logic       ext_ram_n = 1'b1;
  logic       ram_en;
  logic [1:0] region;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [1:0] expq[$];

  always #4 clk = ~clk;

  chipdec_top uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi),
    .as_n(as_n), .ext_ram_n(ext_ram_n), .ram_en(ram_en), .region(region)
  );

  // Reference: byte-address ranges restated independently
  function automatic logic [1:0] ref_region(input logic [6:0] hi, input logic asn,
                                            input logic strapn);
    int a;
    a = int'(hi) * 131072;
    if (asn) return 2'b00;
    if (a < 'h200000) return 2'b01;
    if (!strapn && a >= 'hC00000 && a < 'hD80000) return 2'b10;
    return 2'b00;
  endfunction

  task automatic apply(input logic [6:0] hi, input logic asn, input logic strapn);
    logic [1:0] r;
    logic en_exp;
    @(negedge clk);
    cpu_addr_hi = hi; as_n = asn; ext_ram_n = strapn;
    r = ref_region(hi, asn, strapn);
    en_exp = (r != 2'b00);
    #1;
    checks++;
    if (ram_en !== en_exp) begin
      bad++;
      $display("FAIL %s hi=%0d as_n=%0b strap_n=%0b ram_en actual=%0b expected=%0b",
               asn ? "R5" : (hi < 16 ? "R1" : (hi >= 96 && hi < 108) ?
               (strapn ? "R3" : "R2") : "R4"), hi, asn, strapn, ram_en, en_exp);
    end
    expq.push_back(r);
  endtask

  // Monitor: compares the registered region code after each edge (R6)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expq.size() > 0) begin
        logic [1:0] e;
        e = expq.pop_front();
        checks++;
        if (region !== e) begin
          bad++;
          $display("FAIL R6 region actual=%b expected=%b", region, e);
        end
      end
    end
  end

  initial begin
    #20000000;
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    // R7: reset state, even with a strobed low address present
    as_n = 1'b0; cpu_addr_hi = 7'd0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (region !== 2'b00) begin
      bad++;
      $display("FAIL R7 region actual=%b expected=00", region);
    end
    @(negedge clk);
    as_n = 1'b1;
    rst_n = 1'b1;
    // Full sweep: R1 R2 R3 R4 R5 R6
    for (int s = 0; s < 2; s++) begin
      for (int st = 0; st < 2; st++) begin
        for (int h = 0; h < 128; h++) begin
          apply(7'(h), st[0], s[0]);
        end
      end
    end
    // R5: release strobe right after an enabled access, same cycle
    apply(7'd3, 1'b0, 1'b0);
    apply(7'd3, 1'b1, 1'b0);
    apply(7'd100, 1'b0, 1'b0);
    apply(7'd100, 1'b1, 1'b0);
    // R2/R3: strap toggled on the same upper block
    apply(7'd107, 1'b0, 1'b0);
    apply(7'd107, 1'b0, 1'b1);
    apply(7'd108, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule